// File: doc/BRIEF.md
# Two-Hand Clock Page Sweeper

This block reclaims physical memory frames with a two-hand clock scan. It keeps one status entry per frame (valid, used, dirty, and a write-back pending flag). A leading hand walks the entries one per cycle and clears each used bit it passes. A trailing hand follows a programmable number of frames behind. When the trailing hand finds a valid frame whose used bit is still clear, it reclaims that frame. A clean frame goes onto a free queue and is marked invalid. A dirty frame goes onto a write-back queue and is marked pending.

Any frame referenced between the two hands' visits has its used bit set again, so it survives the sweep. Software or a page walker marks frames as mapped, reports references and writes through the reference port, and reports finished write-backs. A frame whose write-back has finished becomes clean and is reclaimed on the trailing hand's next visit. Both queues are drained by downstream logic with a valid/ready pop.

Top module: `clock_page_sweeper`

## Requirements
- R1: After reset every frame is invalid and both queues are empty (`free_valid_o` = 0, `wb_valid_o` = 0). Sweeping with nothing mapped queues nothing.
- R2: A map request sets the frame valid and used, and clears its dirty and pending state.
- R3: A reference to a valid frame sets its used bit. When `ref_write_i` = 1 it also sets the dirty bit.
- R4: While `sweep_en_i` = 1 and neither queue is full, both hands advance by one frame per cycle, wrapping from frame NUM_FRAMES-1 to frame 0. The leading hand clears the used bit of the valid frame under it. Both hands start at frame 0 after reset.
- R5: The trailing hand's index is (leading index − `gap_i`) modulo NUM_FRAMES. With `gap_i` = 0 both hands share a frame, and the trailing hand sees the used bit as it was before that cycle's clear.
- R6: When the trailing hand finds a valid, clean frame with a clear used bit, the frame number is pushed onto the free queue and the frame becomes invalid.
- R7: When the trailing hand finds a valid, dirty, non-pending frame with a clear used bit, the frame number is pushed onto the write-back queue and the frame becomes pending. Pending frames are passed over.
- R8: A write-back completion clears the frame's dirty and pending state, so the trailing hand's next visit frees it.
- R9: A reference to a frame wins over a hand action on that frame in the same cycle. The used bit stays set, and the trailing hand does not reclaim the frame in that cycle.
- R10: While either queue is full, the hands hold their positions and make no change to any entry.
- R11: Invalid frames are left alone by both hands. A freed frame is never queued again until it is mapped again.
- R12: Each queue delivers frame numbers in push order. Its valid output is high while it is non-empty. An entry is popped in a cycle with valid and ready both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sweep_en_i | input | 1 | Lets the hands advance |
| gap_i | input | FW = clog2(NUM_FRAMES) | Distance by which the trailing hand follows the leading hand |
| map_valid_i | input | 1 | Mark a frame as mapped |
| map_frame_i | input | FW | Frame to mark as mapped |
| ref_valid_i | input | 1 | A reference to a frame occurred |
| ref_frame_i | input | FW | Referenced frame |
| ref_write_i | input | 1 | The reference was a write |
| wb_done_valid_i | input | 1 | A write-back has finished |
| wb_done_frame_i | input | FW | Frame whose write-back finished |
| free_valid_o | output | 1 | Free queue holds a frame |
| free_frame_o | output | FW | Oldest frame on the free queue |
| free_ready_i | input | 1 | Pop the free queue |
| wb_valid_o | output | 1 | Write-back queue holds a frame |
| wb_frame_o | output | FW | Oldest frame on the write-back queue |
| wb_ready_i | input | 1 | Pop the write-back queue |

## Verification
Three patterns exercise the reclaim path.

- All frames mapped, with gaps of 4, 0 and 7: each gap produces a different first frame to be freed, or none. This separates correct trailing-index arithmetic and wrap from an off-by-one or a missing wrap.
- References injected in the exact cycle a hand lands on a frame: the frame must survive that pass and be freed on the next pass. This exposes a wrong priority between the reference port and either hand.
- A dirty frame: it must appear once on the write-back queue, be passed over while pending, and be freed only after its completion. A sparse mapping with the free queue deliberately held full shows that invalid frames are ignored and that a stalled sweep loses no position.

// File: rtl/clk_sweep_pkg.sv
package clk_sweep_pkg;

  typedef struct packed {
    logic valid;
    logic used;
    logic dirty;
    logic busy;   // write-back queued, not yet completed
  } frame_state_t;

  localparam frame_state_t FRAME_RESET = '{valid: 1'b0, used: 1'b0, dirty: 1'b0, busy: 1'b0};
  localparam frame_state_t FRAME_MAPPED = '{valid: 1'b1, used: 1'b1, dirty: 1'b0, busy: 1'b0};

endpackage

// File: rtl/clk_sweep_fifo.sv
module clk_sweep_fifo #(
  parameter int DATA_W = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              full_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              ready_i
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;
  logic              pop, push_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign pop     = valid_o && ready_i;
  assign push_ok = push_i && !full_o;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= ptr_inc(wr_q);
      if (pop)     rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  // R10: the sweeper must stall rather than push into a full queue
  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  // R12: a push without a pop leaves the queue non-empty
  a_r12_push_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop) |=> valid_o);

endmodule

// File: rtl/clk_sweep_table.sv
module clk_sweep_table
  import clk_sweep_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int FW         = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          map_valid_i,
  input  logic [FW-1:0] map_frame_i,
  input  logic          ref_valid_i,
  input  logic [FW-1:0] ref_frame_i,
  input  logic          ref_write_i,
  input  logic          done_valid_i,
  input  logic [FW-1:0] done_frame_i,
  input  logic          clr_en_i,
  input  logic [FW-1:0] clr_idx_i,
  input  logic          free_en_i,
  input  logic          queue_en_i,
  input  logic [FW-1:0] head_idx_i,
  output frame_state_t  head_state_o
);

  frame_state_t st_q [NUM_FRAMES];
  frame_state_t st_d [NUM_FRAMES];

  // Later updates win: hands first, then completion, then references, then mapping
  always_comb begin
    for (int i = 0; i < NUM_FRAMES; i++) begin
      st_d[i] = st_q[i];
      if (clr_en_i && clr_idx_i == FW'(i) && st_q[i].valid) st_d[i].used = 1'b0;
      if (free_en_i && head_idx_i == FW'(i)) begin
        st_d[i].valid = 1'b0;
        st_d[i].used  = 1'b0;
      end
      if (queue_en_i && head_idx_i == FW'(i)) st_d[i].busy = 1'b1;
      if (done_valid_i && done_frame_i == FW'(i)) begin
        st_d[i].dirty = 1'b0;
        st_d[i].busy  = 1'b0;
      end
      if (ref_valid_i && ref_frame_i == FW'(i) && st_q[i].valid) begin
        st_d[i].used = 1'b1;
        if (ref_write_i) st_d[i].dirty = 1'b1;
      end
      if (map_valid_i && map_frame_i == FW'(i)) st_d[i] = FRAME_MAPPED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_FRAMES; i++) st_q[i] <= FRAME_RESET;
    end else begin
      for (int i = 0; i < NUM_FRAMES; i++) st_q[i] <= st_d[i];
    end
  end

  assign head_state_o = st_q[head_idx_i];

  // R6: only valid, clean, unreferenced frames are freed
  a_r6_free_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_en_i |-> (head_state_o.valid && !head_state_o.used && !head_state_o.dirty));

  // R11: a freed frame is invalid afterwards
  a_r11_freed_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_en_i |=> !st_q[$past(head_idx_i)].valid);

  // R7: write-back is queued only for dirty frames not already pending
  a_r7_queue_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    queue_en_i |-> (head_state_o.dirty && !head_state_o.busy));

  // R9: a reference to a valid frame always leaves it used
  a_r9_ref_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && st_q[ref_frame_i].valid) |=> st_q[$past(ref_frame_i)].used);

endmodule

// File: rtl/clk_sweep_hands.sv
module clk_sweep_hands
  import clk_sweep_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int FW         = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sweep_en_i,
  input  logic [FW-1:0] gap_i,
  input  logic          stall_i,
  input  frame_state_t  head_state_i,
  input  logic          map_valid_i,
  input  logic [FW-1:0] map_frame_i,
  input  logic          ref_valid_i,
  input  logic [FW-1:0] ref_frame_i,
  output logic [FW-1:0] tail_o,
  output logic [FW-1:0] head_o,
  output logic          clr_en_o,
  output logic          free_en_o,
  output logic          queue_en_o
);

  localparam logic [FW:0] NF_W = (FW + 1)'(NUM_FRAMES);

  logic [FW-1:0] tail_q;
  logic [FW:0]   gap_w, head_w;
  logic          step, touched, eligible;

  assign step = sweep_en_i && !stall_i;

  // gap_i may exceed NUM_FRAMES-1 when the frame count is not a power of two
  always_comb begin
    gap_w = {1'b0, gap_i};
    if (gap_w >= NF_W) gap_w = gap_w - NF_W;
    if ({1'b0, tail_q} >= gap_w) head_w = {1'b0, tail_q} - gap_w;
    else                         head_w = {1'b0, tail_q} + NF_W - gap_w;
  end

  assign tail_o = tail_q;
  assign head_o = head_w[FW-1:0];

  assign touched  = (ref_valid_i && ref_frame_i == head_o) ||
                    (map_valid_i && map_frame_i == head_o);
  assign eligible = step && head_state_i.valid && !head_state_i.used &&
                    !head_state_i.busy && !touched;

  assign clr_en_o   = step;
  assign free_en_o  = eligible && !head_state_i.dirty;
  assign queue_en_o = eligible && head_state_i.dirty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tail_q <= '0;
    else if (step) tail_q <= (tail_q == FW'(NUM_FRAMES - 1)) ? '0 : tail_q + 1'b1;
  end

  // R4: one frame per enabled cycle, wrapping at the last frame
  a_r4_tail_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_en_i && !stall_i) |=>
      (tail_q == (($past(tail_q) == FW'(NUM_FRAMES - 1)) ? '0 : $past(tail_q) + 1'b1)));

  // R10: hands hold while stalled or disabled
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sweep_en_i || stall_i) |=> $stable(tail_q));

  // R9: a frame touched this cycle is never reclaimed this cycle
  a_r9_no_reclaim_touched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && ref_frame_i == head_o) |-> !(free_en_o || queue_en_o));

endmodule

// File: rtl/clock_page_sweeper.sv
module clock_page_sweeper
  import clk_sweep_pkg::*;
#(
  parameter int NUM_FRAMES  = 8,
  parameter int QUEUE_DEPTH = 4,
  localparam int FW         = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sweep_en_i,
  input  logic [FW-1:0] gap_i,
  input  logic          map_valid_i,
  input  logic [FW-1:0] map_frame_i,
  input  logic          ref_valid_i,
  input  logic [FW-1:0] ref_frame_i,
  input  logic          ref_write_i,
  input  logic          wb_done_valid_i,
  input  logic [FW-1:0] wb_done_frame_i,
  output logic          free_valid_o,
  output logic [FW-1:0] free_frame_o,
  input  logic          free_ready_i,
  output logic          wb_valid_o,
  output logic [FW-1:0] wb_frame_o,
  input  logic          wb_ready_i
);

  logic          free_full, wb_full, stall;
  logic          clr_en, free_en, queue_en;
  logic [FW-1:0] tail_idx, head_idx;
  frame_state_t  head_state;

  assign stall = free_full || wb_full;

  clk_sweep_table #(.NUM_FRAMES(NUM_FRAMES), .FW(FW)) i_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .map_valid_i  (map_valid_i),
    .map_frame_i  (map_frame_i),
    .ref_valid_i  (ref_valid_i),
    .ref_frame_i  (ref_frame_i),
    .ref_write_i  (ref_write_i),
    .done_valid_i (wb_done_valid_i),
    .done_frame_i (wb_done_frame_i),
    .clr_en_i     (clr_en),
    .clr_idx_i    (tail_idx),
    .free_en_i    (free_en),
    .queue_en_i   (queue_en),
    .head_idx_i   (head_idx),
    .head_state_o (head_state)
  );

  clk_sweep_hands #(.NUM_FRAMES(NUM_FRAMES), .FW(FW)) i_hands (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sweep_en_i   (sweep_en_i),
    .gap_i        (gap_i),
    .stall_i      (stall),
    .head_state_i (head_state),
    .map_valid_i  (map_valid_i),
    .map_frame_i  (map_frame_i),
    .ref_valid_i  (ref_valid_i),
    .ref_frame_i  (ref_frame_i),
    .tail_o       (tail_idx),
    .head_o       (head_idx),
    .clr_en_o     (clr_en),
    .free_en_o    (free_en),
    .queue_en_o   (queue_en)
  );

  clk_sweep_fifo #(.DATA_W(FW), .DEPTH(QUEUE_DEPTH)) i_free_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (free_en),
    .data_i  (head_idx),
    .full_o  (free_full),
    .valid_o (free_valid_o),
    .data_o  (free_frame_o),
    .ready_i (free_ready_i)
  );

  clk_sweep_fifo #(.DATA_W(FW), .DEPTH(QUEUE_DEPTH)) i_wb_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (queue_en),
    .data_i  (head_idx),
    .full_o  (wb_full),
    .valid_o (wb_valid_o),
    .data_o  (wb_frame_o),
    .ready_i (wb_ready_i)
  );

  // R6, R7: a visited frame goes to at most one queue
  a_r7_one_queue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({free_en, queue_en}));

endmodule

// File: tb/test_clock_page_sweeper.sv
module test_clock_page_sweeper;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int FW = 3;
  localparam int QD = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sweep_en = 1'b0;
  logic [FW-1:0] gap = '0;
  logic map_valid = 1'b0, ref_valid = 1'b0, ref_write = 1'b0, done_valid = 1'b0;
  logic [FW-1:0] map_frame = '0, ref_frame = '0, done_frame = '0;
  logic free_ready = 1'b1, wb_ready = 1'b1;
  logic free_valid, wb_valid;
  logic [FW-1:0] free_frame, wb_frame;

  int total = 0, bad = 0;
  bit finished = 0;
  int free_log[$];
  int wb_log[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clock_page_sweeper #(.NUM_FRAMES(NF), .QUEUE_DEPTH(QD)) i_clock_page_sweeper (
    .clk_i(clk), .rst_ni(rst_ni), .sweep_en_i(sweep_en), .gap_i(gap),
    .map_valid_i(map_valid), .map_frame_i(map_frame),
    .ref_valid_i(ref_valid), .ref_frame_i(ref_frame), .ref_write_i(ref_write),
    .wb_done_valid_i(done_valid), .wb_done_frame_i(done_frame),
    .free_valid_o(free_valid), .free_frame_o(free_frame), .free_ready_i(free_ready),
    .wb_valid_o(wb_valid), .wb_frame_o(wb_frame), .wb_ready_i(wb_ready)
  );

  // Pops are recorded mid-phase, before the edge that performs them
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_ni) begin
      if (free_valid && free_ready) free_log.push_back(int'(free_frame));
      if (wb_valid && wb_ready)     wb_log.push_back(int'(wb_frame));
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // seq lists frames as hex nibbles, oldest first
  task automatic check_seq(input string req, input bit is_wb, input int n, input logic [31:0] seq);
    int got_n;
    got_n = is_wb ? wb_log.size() : free_log.size();
    check_eq(req, is_wb ? "wb queue count" : "free queue count", got_n, n);
    for (int k = 0; k < n && k < got_n; k++)
      check_eq(req, is_wb ? "wb queue entry" : "free queue entry",
               is_wb ? wb_log[k] : free_log[k], int'(seq[4*(n-1-k) +: 4]));
    if (is_wb) wb_log.delete(); else free_log.delete();
  endtask

  task automatic do_reset(input logic [FW-1:0] g);
    @(negedge clk);
    rst_ni = 1'b0;
    sweep_en = 0; map_valid = 0; ref_valid = 0; ref_write = 0; done_valid = 0;
    free_ready = 1; wb_ready = 1; gap = g;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    free_log.delete();
    wb_log.delete();
  endtask

  task automatic map_frames(input logic [NF-1:0] mask);
    for (int f = 0; f < NF; f++) begin
      if (mask[f]) begin
        @(negedge clk);
        map_valid = 1'b1;
        map_frame = FW'(f);
      end
    end
    @(negedge clk);
    map_valid = 1'b0;
  endtask

  task automatic touch(input int f, input bit wr);
    @(negedge clk);
    ref_valid = 1'b1; ref_frame = FW'(f); ref_write = wr;
    @(negedge clk);
    ref_valid = 1'b0; ref_write = 1'b0;
  endtask

  task automatic sweep(input int n);
    @(negedge clk);
    sweep_en = 1'b1;
    repeat (n) @(negedge clk);
    sweep_en = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    free_ready = 1'b1; wb_ready = 1'b1;
    repeat (QD + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(FW'(4));
    check_eq("R1", "free_valid after reset", int'(free_valid), 0);
    check_eq("R1", "wb_valid after reset", int'(wb_valid), 0);
    sweep(10);
    drain();
    check_seq("R1", 0, 0, 32'h0);
    check_seq("R1", 1, 0, 32'h0);
  endtask

  task automatic t_clean_stall();
    do_reset(FW'(4));
    free_ready = 0; wb_ready = 0;
    map_frames(8'hFF);
    sweep(8);
    check_eq("R10", "free_valid when full", int'(free_valid), 1);
    check_eq("R12", "oldest free frame", int'(free_frame), 0);
    check_eq("R6", "wb_valid clean pages", int'(wb_valid), 0);
    sweep(6);   // queue full: hands must hold
    drain();
    check_seq("R6", 0, 4, 32'h0123);
    sweep(4);
    drain();
    check_seq("R10", 0, 4, 32'h4567);
    check_seq("R2", 1, 0, 32'h0);
  endtask

  task automatic t_reference();
    do_reset(FW'(4));
    map_frames(8'hFF);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      sweep_en = 1'b1;
      ref_valid = (c == 1) || (c == 6);   // c1: lead on frame 1; c6: trail on frame 2
      ref_frame = (c == 6) ? FW'(2) : FW'(1);
      ref_write = 1'b0;
    end
    @(negedge clk);
    sweep_en = 1'b0; ref_valid = 1'b0;
    drain();
    check_seq("R9", 0, 2, 32'h03);
    sweep(8);
    drain();
    check_seq("R3", 0, 6, 32'h456712);
  endtask

  task automatic t_writeback();
    do_reset(FW'(4));
    map_frames(8'hFF);
    touch(2, 1'b1);
    sweep(8);
    drain();
    check_seq("R7", 0, 3, 32'h013);
    check_seq("R7", 1, 1, 32'h2);
    sweep(8);   // frame 2 pending: passed over
    drain();
    check_seq("R7", 0, 4, 32'h4567);
    check_seq("R7", 1, 0, 32'h0);
    @(negedge clk);
    done_valid = 1'b1; done_frame = FW'(2);
    @(negedge clk);
    done_valid = 1'b0;
    sweep(8);
    drain();
    check_seq("R8", 0, 1, 32'h2);
    check_seq("R8", 1, 0, 32'h0);
  endtask

  task automatic t_sparse();
    do_reset(FW'(4));
    map_frames(8'b0100_0010);
    sweep(16);
    drain();
    check_seq("R11", 0, 2, 32'h16);
    check_seq("R11", 1, 0, 32'h0);
  endtask

  task automatic t_gap();
    do_reset(FW'(0));
    map_frames(8'hFF);
    sweep(8);
    drain();
    check_seq("R5", 0, 0, 32'h0);
    sweep(8);
    drain();
    check_seq("R4", 0, 8, 32'h01234567);
    do_reset(FW'(7));
    map_frames(8'hFF);
    sweep(8);
    drain();
    check_seq("R5", 0, 1, 32'h0);
  endtask

  initial begin
    t_reset();
    t_clean_stall();
    t_reference();
    t_writeback();
    t_sparse();
    t_gap();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule